// File: doc/BRIEF.md
# Step-by-step I2C bus master

This block is an I2C bus master that software walks through one bus phase at a time. Software writes a control byte that requests a START, a STOP or the next byte transfer. The controller performs that single phase on SCL and SDA and then halts with its flag bit set. It also publishes an 8-bit code that names the outcome of the phase. Nothing further happens on the bus until software writes the control byte again with the flag bit at zero. While the controller is halted, it keeps SCL pulled low so that the bus stays owned.

Both bus lines are open-drain. The outputs `scl_oe` and `sda_oe` pull a line low when they are high, and `sda_i` returns the resolved SDA level. The controller tracks where it stands in a transfer: the first address byte, the second byte of a 10-bit address, or data. From this it derives the direction of each byte and the code it reports. When the master releases SDA but sees it low during a bit it sends, it has lost arbitration. It then lets go of the bus.

Top module: `i2cm_top`

## Requirements
- R1: The control register is at offset 1. Its bits are: bit 2 ACK-on-receive, bit 3 done flag, bit 4 STOP request, bit 5 START request, bit 6 enable and bit 7 interrupt enable. `irq` is high exactly while both the flag and interrupt enable are set, and it falls on the edge that writes either of them to zero. Writing 1 to bit 3 keeps the flag; writing 0 clears it and, if bit 6 is set, launches the next phase.
- R2: A START requested from an idle bus ends with status 0x08 (status register at offset 2). The flag is set, and both lines are held low.
- R3: A START requested while the master owns the bus produces a repeated START and status 0x10.
- R4: The first byte after a START is an address byte whose bit 0 selects read (1) or write (0). It reports 0x18 for write+ACK, 0x20 for write+NACK, 0x40 for read+ACK and 0x48 for read+NACK.
- R5: In the write direction, the byte in the data register (offset 0) is sent MSB first. The result is 0x28 when the slave ACKs and 0x30 when it NACKs.
- R6: In the read direction, each received byte lands in the data register. The master drives ACK (SDA low) on the ninth clock when bit 2 was 1 in the write that launched that byte, and the status is then 0x50. Otherwise it leaves SDA high and the status is 0x58.
- R7: An address byte of the form 11110xxR starts a 10-bit address. The byte that follows is the second address byte and reports 0xD0 or 0xD8 (write, ACK or NACK), or 0xE0 or 0xE8 (read, ACK or NACK).
- R8: A STOP releases both lines, with SDA rising while SCL is high. It sets status 0xF8, clears the STOP bit and does not set the flag.
- R9: If SDA reads low while the master releases it with SCL high during a sent bit, both lines are released. The status becomes 0x38, the flag is set and ownership is dropped, so the next START reports 0x08.
- R10: Any write to offset 3 returns the status to 0xF8 and clears every control bit except enable. It also releases both lines and drops ownership.
- R11: While the flag is set, both line drivers stay unchanged.
- R12: After reset, the status reads 0xF8, the control register reads 0, both lines are released and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 data, 1 control, 2 status, 3 soft reset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A wrong internal phase, such as a missed 10-bit second byte or the wrong direction after a read address, shows up as a wrong status code the moment the flag rises for the next byte. That happens within one byte time. A wrong ACK decision shows on SDA during the ninth clock of that same byte and again in the 0x50/0x58 code. Lost ownership is caught at the next START, which reports 0x08 instead of 0x10. A driver that moves while the flag is set breaks the hold rule on the first cycle it happens.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_SRST = 2'd3;

  localparam int CB_ACK = 2;
  localparam int CB_FLG = 3;
  localparam int CB_STO = 4;
  localparam int CB_STA = 5;
  localparam int CB_EN  = 6;
  localparam int CB_IEN = 7;

  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NACK = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NACK = 8'h30;
  localparam logic [7:0] SC_ARB     = 8'h38;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NACK = 8'h48;
  localparam logic [7:0] SC_DR_ACK  = 8'h50;
  localparam logic [7:0] SC_DR_NACK = 8'h58;
  localparam logic [7:0] SC_A2W_ACK = 8'hD0;
  localparam logic [7:0] SC_A2W_NAK = 8'hD8;
  localparam logic [7:0] SC_A2R_ACK = 8'hE0;
  localparam logic [7:0] SC_A2R_NAK = 8'hE8;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  typedef enum logic [1:0] {CK_START, CK_STOP, CK_WRITE, CK_READ} i2cm_cmd_e;
  typedef enum logic [1:0] {PH_ADDR1, PH_ADDR2, PH_DATA} i2cm_phase_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QTR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(QTR - 1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (restart)   cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       cmd_valid,
  input  i2cm_cmd_e  cmd,
  input  logic [7:0] tx_byte,
  input  logic       ack_out,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output logic       arb_lost,
  output logic       ack_seen,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);
  typedef enum logic [1:0] {E_IDLE, E_START, E_STOP, E_BIT} eng_e;

  eng_e       st;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [8:0] shreg;
  logic [8:0] rxs;
  logic       is_wr;
  logic       tick;
  logic       accept;

  assign accept   = (st == E_IDLE) && cmd_valid && !abort;
  assign busy     = (st != E_IDLE);
  assign rx_byte  = rxs[8:1];
  assign ack_seen = !rxs[0];

  i2cm_qtick #(.QTR(QTR)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; q <= 2'd0; bitn <= 4'd0; shreg <= '0; rxs <= '1;
      is_wr <= 1'b0; done <= 1'b0; arb_lost <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done     <= 1'b0;
      arb_lost <= 1'b0;
      if (abort) begin
        st <= E_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (accept) begin
        q     <= 2'd0;
        bitn  <= 4'd0;
        is_wr <= (cmd == CK_WRITE);
        shreg <= (cmd == CK_WRITE) ? {tx_byte, 1'b1} : {8'hFF, ~ack_out};
        unique case (cmd)
          CK_START: st <= E_START;
          CK_STOP:  st <= E_STOP;
          default:  st <= E_BIT;
        endcase
      end else if (busy && tick) begin
        q <= q + 2'd1;
        unique case (st)
          E_START: unique case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin scl_oe <= 1'b1; st <= E_IDLE; done <= 1'b1; end
          endcase
          E_STOP: unique case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin st <= E_IDLE; done <= 1'b1; end
          endcase
          default: unique case (q)
            2'd0: sda_oe <= ~shreg[8];
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              rxs <= {rxs[7:0], sda_i};
              if (is_wr && shreg[8] && !sda_i && bitn != 4'd8) begin
                scl_oe <= 1'b0; sda_oe <= 1'b0;
                st <= E_IDLE; done <= 1'b1; arb_lost <= 1'b1;
              end
            end
            default: begin
              scl_oe <= 1'b1;
              shreg  <= {shreg[7:0], 1'b0};
              if (bitn == 4'd8) begin st <= E_IDLE; done <= 1'b1; end
              else bitn <= bitn + 4'd1;
            end
          endcase
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic        ack_en_q, iflg_q, sto_q, sta_q, en_q, ien_q;
  logic [7:0]  data_q, stat_q;
  logic        owned_q, rd_q, ten_q, ack_sent_q;
  i2cm_phase_e phase_q;
  i2cm_cmd_e   cur_q, lcmd;
  logic        cmd_ok, ctrl_wr, sreset, launch;
  logic        eng_busy, eng_done, eng_arb, eng_ack;
  logic [7:0]  eng_rx;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign sreset  = reg_wr && (reg_addr == RA_SRST);
  assign irq     = iflg_q && ien_q;

  always_comb begin
    lcmd   = CK_WRITE;
    cmd_ok = 1'b0;
    if (reg_wdata[CB_STA]) begin
      lcmd = CK_START; cmd_ok = 1'b1;
    end else if (reg_wdata[CB_STO]) begin
      lcmd = CK_STOP; cmd_ok = owned_q;
    end else if (owned_q) begin
      lcmd   = (phase_q == PH_DATA && rd_q) ? CK_READ : CK_WRITE;
      cmd_ok = 1'b1;
    end
  end

  assign launch = ctrl_wr && !reg_wdata[CB_FLG] && reg_wdata[CB_EN] && !eng_busy && cmd_ok;

  always_comb begin
    unique case (reg_addr)
      RA_DATA: reg_rdata = data_q;
      RA_CTRL: reg_rdata = {ien_q, en_q, sta_q, sto_q, iflg_q, ack_en_q, 2'b00};
      RA_STAT: reg_rdata = stat_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  i2cm_bit_engine #(.QTR(QTR)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(sreset),
    .cmd_valid(launch), .cmd(lcmd), .tx_byte(data_q), .ack_out(reg_wdata[CB_ACK]),
    .sda_i(sda_i), .busy(eng_busy), .done(eng_done), .arb_lost(eng_arb),
    .ack_seen(eng_ack), .rx_byte(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en_q <= 1'b0; iflg_q <= 1'b0; sto_q <= 1'b0; sta_q <= 1'b0;
      en_q <= 1'b0; ien_q <= 1'b0; data_q <= 8'h00; stat_q <= SC_IDLE;
      owned_q <= 1'b0; rd_q <= 1'b0; ten_q <= 1'b0; ack_sent_q <= 1'b0;
      phase_q <= PH_ADDR1; cur_q <= CK_START;
    end else if (sreset) begin
      ack_en_q <= 1'b0; iflg_q <= 1'b0; sto_q <= 1'b0; sta_q <= 1'b0;
      ien_q <= 1'b0; stat_q <= SC_IDLE; owned_q <= 1'b0; phase_q <= PH_ADDR1;
    end else begin
      if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
      if (ctrl_wr) begin
        ack_en_q <= reg_wdata[CB_ACK];
        sto_q    <= reg_wdata[CB_STO];
        sta_q    <= reg_wdata[CB_STA];
        en_q     <= reg_wdata[CB_EN];
        ien_q    <= reg_wdata[CB_IEN];
        if (!reg_wdata[CB_FLG]) iflg_q <= 1'b0;
      end
      if (launch) begin
        cur_q      <= lcmd;
        ack_sent_q <= reg_wdata[CB_ACK];
        if (lcmd == CK_WRITE && phase_q == PH_ADDR1) begin
          rd_q  <= data_q[0];
          ten_q <= (data_q[7:3] == 5'b11110);
        end
      end
      if (eng_done) begin
        unique case (cur_q)
          CK_START: begin
            stat_q <= owned_q ? SC_RSTART : SC_START;
            owned_q <= 1'b1; phase_q <= PH_ADDR1; sta_q <= 1'b0; iflg_q <= 1'b1;
          end
          CK_STOP: begin
            stat_q <= SC_IDLE; owned_q <= 1'b0; sto_q <= 1'b0;
          end
          CK_READ: begin
            data_q <= eng_rx; iflg_q <= 1'b1;
            stat_q <= ack_sent_q ? SC_DR_ACK : SC_DR_NACK;
          end
          default: begin
            iflg_q <= 1'b1;
            if (eng_arb) begin
              stat_q <= SC_ARB; owned_q <= 1'b0;
            end else begin
              unique case (phase_q)
                PH_ADDR1: begin
                  stat_q  <= rd_q ? (eng_ack ? SC_AR_ACK : SC_AR_NACK)
                                  : (eng_ack ? SC_AW_ACK : SC_AW_NACK);
                  phase_q <= ten_q ? PH_ADDR2 : PH_DATA;
                end
                PH_ADDR2: begin
                  stat_q  <= rd_q ? (eng_ack ? SC_A2R_ACK : SC_A2R_NAK)
                                  : (eng_ack ? SC_A2W_ACK : SC_A2W_NAK);
                  phase_q <= PH_DATA;
                end
                default: stat_q <= eng_ack ? SC_DW_ACK : SC_DW_NACK;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       iflg,
  input logic [7:0] status
);
  // R1: the interrupt never stands without the done flag
  p_irq_needs_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> iflg);

  // R11: drivers frozen while software has not released the flag
  p_hold_while_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && $past(iflg)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  // R8: idle status never carries a pending flag
  p_idle_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'hF8) |-> !iflg);

  // R2: after a START both lines are held low
  p_start_holds_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && status == 8'h08) |-> (scl_oe && sda_oe));

  // R9: arbitration loss lets go of both lines
  p_arb_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iflg) && status == 8'h38) |-> (!scl_oe && !sda_oe));

  // R10: soft reset lands in idle with the bus released
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> (status == 8'hF8 && !scl_oe && !sda_oe && !irq));
endmodule

bind i2cm_top i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .iflg(iflg_q), .status(stat_q)
);

// File: tb/i2cm_top_test.sv
module i2cm_top_test;
  localparam logic [7:0] F_ACK = 8'h04, F_FLG = 8'h08, F_STO = 8'h10;
  localparam logic [7:0] F_STA = 8'h20, F_EN = 8'h40, F_IEN = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire        irq, scl_oe, sda_oe;

  // behavioural slave on the open-drain bus
  logic       slv_tx_mode = 1'b0;
  logic       slv_ack = 1'b1;
  logic [7:0] slv_tx = 8'h00;
  int         slv_bit = 0;
  bit         slv_rise = 1'b0;
  logic [7:0] slv_sh = 8'h00, slv_rx = 8'h00;
  logic       slv_ack_seen = 1'b0;
  int         slv_starts = 0;
  logic       slv_low;

  always_comb begin
    if (slv_bit < 8) slv_low = slv_tx_mode && !slv_tx[3'(7 - slv_bit)];
    else             slv_low = !slv_tx_mode && slv_ack;
  end

  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || slv_low);

  always @(negedge sda_w) if (scl_w) begin slv_bit = 0; slv_rise = 1'b0; slv_starts++; end
  always @(posedge scl_w) begin
    slv_rise = 1'b1;
    if (slv_bit < 8) slv_sh = {slv_sh[6:0], sda_w};
    else begin slv_rx = slv_sh; slv_ack_seen = !sda_w; end
  end
  always @(negedge scl_w) if (slv_rise) begin
    slv_rise = 1'b0;
    slv_bit = (slv_bit == 8) ? 0 : slv_bit + 1;
  end

  i2cm_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_err = 0, mon_err = 0;
  bit m_ien = 1'b0;
  bit finished = 1'b0;

  // per-cycle model: irq may only be high when the bench has enabled it (R1)
  always @(negedge clk) begin
    #1;
    if (rst_n && irq && !m_ien) mon_err++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
    if (a == 2'd1) m_ien = d[7];
    if (a == 2'd3) m_ien = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 2'd2;
  endtask

  task automatic wait_flag(input string tag);
    int waited = 0;
    while (irq !== 1'b1 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (irq !== 1'b1) begin
      n_chk++; n_err++;
      $display("FAIL %s: actual no-flag expected flag", tag);
    end
  endtask

  task automatic op_start(input string tag);
    wr(2'd1, F_IEN | F_EN | F_STA);
    wait_flag(tag);
  endtask

  task automatic op_byte(input logic [7:0] d, input string tag);
    wr(2'd0, d);
    wr(2'd1, F_IEN | F_EN);
    wait_flag(tag);
  endtask

  task automatic op_read(input bit ack, input string tag);
    wr(2'd1, F_IEN | F_EN | (ack ? F_ACK : 8'h00));
    wait_flag(tag);
  endtask

  task automatic expect_stat(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    rd(2'd2, s);
    chk(tag, {8'h00, s}, {8'h00, exp});
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      chk("R1 per-cycle irq model mismatches", 16'(mon_err), 16'd0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    expect_stat("R12 status after reset", 8'hF8);
    rd(2'd1, v); chk("R12 control after reset", {8'h00, v}, 16'h0000);
    chk("R12 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);
    chk("R12 irq low", {15'd0, irq}, 16'd0);

    // R2 start from idle
    op_start("R2 start");
    expect_stat("R2 status start", 8'h08);
    chk("R2 lines held low", {14'd0, scl_oe, sda_oe}, 16'd3);
    chk("R2 slave saw start", 16'(slv_starts), 16'd1);

    // R1 control layout and irq gating
    rd(2'd1, v); chk("R1 control readback", {8'h00, v}, {8'h00, F_IEN | F_EN | F_FLG});
    wr(2'd1, F_EN | F_FLG);
    chk("R1 irq drops with enable", {15'd0, irq}, 16'd0);
    rd(2'd1, v); chk("R1 flag kept on write of one", {8'h00, v}, {8'h00, F_EN | F_FLG});
    wr(2'd1, F_IEN | F_EN | F_FLG);
    chk("R1 irq back", {15'd0, irq}, 16'd1);

    // R11 no progress while flag set
    repeat (60) @(negedge clk);
    chk("R11 scl held while flag set", {15'd0, scl_oe}, 16'd1);
    expect_stat("R11 status unchanged", 8'h08);

    // R4 write address, R5 data
    slv_ack = 1'b1;
    op_byte(8'hA0, "R4 addr write");
    expect_stat("R4 addr write ack", 8'h18);
    chk("R4 slave got address", {8'h00, slv_rx}, 16'h00A0);
    op_byte(8'h3C, "R5 data");
    expect_stat("R5 data ack", 8'h28);
    chk("R5 slave got data", {8'h00, slv_rx}, 16'h003C);
    slv_ack = 1'b0;
    op_byte(8'h11, "R5 data nack");
    expect_stat("R5 data nack", 8'h30);
    slv_ack = 1'b1;

    // R3 repeated start, read
    op_start("R3 restart");
    expect_stat("R3 status restart", 8'h10);
    op_byte(8'hA1, "R4 addr read");
    expect_stat("R4 addr read ack", 8'h40);

    // R6 receive with ack then nack
    slv_tx_mode = 1'b1; slv_tx = 8'h5A;
    op_read(1'b1, "R6 read ack");
    expect_stat("R6 status ack", 8'h50);
    rd(2'd0, v); chk("R6 data 5A", {8'h00, v}, 16'h005A);
    chk("R6 master drove ack", {15'd0, slv_ack_seen}, 16'd1);
    slv_tx = 8'hC3;
    op_read(1'b0, "R6 read nack");
    expect_stat("R6 status nack", 8'h58);
    rd(2'd0, v); chk("R6 data C3", {8'h00, v}, 16'h00C3);
    chk("R6 master left nack", {15'd0, slv_ack_seen}, 16'd0);
    slv_tx_mode = 1'b0;

    // R8 stop
    wr(2'd1, F_IEN | F_EN | F_STO);
    repeat (60) @(negedge clk);
    expect_stat("R8 status idle", 8'hF8);
    chk("R8 no flag", {15'd0, irq}, 16'd0);
    chk("R8 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);
    chk("R8 sda high", {15'd0, sda_w}, 16'd1);
    rd(2'd1, v); chk("R8 stop bit cleared", {8'h00, v}, {8'h00, F_IEN | F_EN});

    // R4 nack codes
    slv_ack = 1'b0;
    op_start("R2 start again");
    expect_stat("R2 start after stop", 8'h08);
    op_byte(8'hA0, "R4 addr write nack");
    expect_stat("R4 addr write nack", 8'h20);
    op_start("R3 restart 2");
    op_byte(8'hA1, "R4 addr read nack");
    expect_stat("R4 addr read nack", 8'h48);
    slv_ack = 1'b1;

    // R7 ten-bit addressing
    op_start("R7 restart");
    op_byte(8'hF2, "R7 first write");
    expect_stat("R7 first write ack", 8'h18);
    chk("R7 first byte on wire", {8'h00, slv_rx}, 16'h00F2);
    op_byte(8'h34, "R7 second write");
    expect_stat("R7 second write ack", 8'hD0);
    op_start("R7 restart b");
    op_byte(8'hF3, "R7 first read");
    expect_stat("R7 first read ack", 8'h40);
    op_byte(8'h77, "R7 second read");
    expect_stat("R7 second read ack", 8'hE0);
    chk("R7 second byte on wire", {8'h00, slv_rx}, 16'h0077);
    op_start("R7 restart c");
    op_byte(8'hF6, "R7 first write c");
    slv_ack = 1'b0;
    op_byte(8'h12, "R7 second write nack");
    expect_stat("R7 second write nack", 8'hD8);
    slv_ack = 1'b1;
    op_start("R7 restart d");
    op_byte(8'hF7, "R7 first read d");
    slv_ack = 1'b0;
    op_byte(8'h99, "R7 second read nack");
    expect_stat("R7 second read nack", 8'hE8);
    slv_ack = 1'b1;

    // R9 arbitration loss
    op_start("R9 restart");
    op_byte(8'hA0, "R9 addr");
    slv_tx_mode = 1'b1; slv_tx = 8'h00;
    op_byte(8'hFF, "R9 contested byte");
    expect_stat("R9 status arb", 8'h38);
    chk("R9 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);
    slv_tx_mode = 1'b0;
    op_start("R9 start after loss");
    expect_stat("R9 ownership dropped", 8'h08);

    // R10 soft reset while owning the bus
    wr(2'd3, 8'h00);
    expect_stat("R10 status idle", 8'hF8);
    rd(2'd1, v); chk("R10 only enable kept", {8'h00, v}, {8'h00, F_EN});
    chk("R10 lines released", {14'd0, scl_oe, sda_oe}, 16'd0);
    chk("R10 irq low", {15'd0, irq}, 16'd0);
    op_start("R10 start after reset");
    expect_stat("R10 fresh start", 8'h08);

    report();
  end
endmodule